// File: doc/BRIEF.md
# Conflict-Free Four-Bank Address Generator

This block maps FFT sample indices onto a data memory split into four banks. The banks can serve four reads and four writes in the same cycle. For every index presented on a lane, it returns a 2-bit bank number and the word address inside that bank. The FFT runs in place: a butterfly writes its results back to the locations it read. The mapping ensures that the four operands of any radix-4 butterfly, in any stage and at any transform size from 64 to 8192 points, sit in four different banks. The same holds for the two operands of the extra radix-2 stage that sizes with an odd log2 need.

The bank number is the modulo-4 sum of the base-4 digits of the index. A small adder tree forms it. No lookup table is used, so one rule covers every size. For odd-log2 sizes, the top index bit sits in the low half of a digit, so it enters the sum as a base-2 digit. The in-bank address is the index without its two low bits. The block is purely combinational and has several lanes, so one butterfly's operands can be translated together. The size is given as log2 of the point count, and index bits at or above that size are ignored.

Top module: `four_bank_addr_gen`

## Requirements
- R1: For each lane, bank_o equals the modulo-4 sum of the base-4 digits of the masked index, where digit k is index bits [2k+1:2k]. Lane n occupies bank_o bits [2n+1:2n].
- R2: For each lane, the in-bank address equals the masked index shifted right by two bits. Lane n occupies addr_o bits [11n+10:11n] and idx_i bits [13n+12:13n].
- R3: Index bits at positions equal to or above the effective size log2 have no effect on bank or address.
- R4: A size setting below 6 behaves as 6, and a setting above 13 behaves as 13. Settings from 6 to 13 are used as given.
- R5: Four indices that differ only in one base-4 digit, taking all four values of it, map to four distinct banks. This holds at every digit position inside the size and for every size.
- R6: For odd sizes (log2 7, 9, 11, 13), two indices that differ only in bit log2-1 map to different banks.
- R7: Every lane's outputs depend only on its own index and the size setting, and they are valid combinationally in the cycle the inputs are presented.
- R8: Within one size, no two different masked indices share the same bank and in-bank address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_log2_i | input | 4 | log2 of the FFT size, clamped to 6..13 |
| idx_i | input | 52 | Four packed 13-bit sample indices, lane 0 in the low bits |
| bank_o | output | 8 | Four packed 2-bit bank numbers |
| addr_o | output | 44 | Four packed 11-bit in-bank addresses |

## Verification
Translating the operands of one butterfly on all lanes at once is the central case. Bank-conflict freedom (R5, R6) is only meaningful when those lookups land in the same cycle. The bench drives a complete radix-4 group, or two radix-2 pairs, on the four lanes in one cycle. It does this at every digit position and every size, with the digit values rotated across the lanes. A lookup is judged correct when every lane matches an independently computed digit sum and shifted address. A group is judged conflict-free when the banks read back from the lanes are pairwise different. An exhaustive sweep of the 64-point space then confirms that no bank and address pair is reused.

// File: rtl/fab_pkg.sv
package fab_pkg;

  localparam int CFG_W = 4;

  typedef logic [1:0] bank_t;

  // Clamp a requested size exponent into the supported window.
  function automatic logic [CFG_W-1:0] clamp_log2(input logic [CFG_W-1:0] req,
                                                   input logic [CFG_W-1:0] lo,
                                                   input logic [CFG_W-1:0] hi);
    logic [CFG_W-1:0] r;
    if (req < lo)      r = lo;
    else if (req > hi) r = hi;
    else               r = req;
    return r;
  endfunction

  // Number of leaves of a balanced binary tree covering n inputs.
  function automatic int tree_leaves(input int n);
    int l;
    l = 1;
    while (l < n) l = l * 2;
    return l;
  endfunction

endpackage

// File: rtl/fab_size_ctl.sv
module fab_size_ctl
  import fab_pkg::*;
#(
  parameter int IDX_W    = 13,
  parameter int MIN_LOG2 = 6
) (
  input  logic [CFG_W-1:0] cfg_log2_i,
  output logic [CFG_W-1:0] eff_log2_o,
  output logic [IDX_W-1:0] mask_o
);

  localparam logic [CFG_W-1:0] LO = CFG_W'(MIN_LOG2);
  localparam logic [CFG_W-1:0] HI = CFG_W'(IDX_W);

  assign eff_log2_o = clamp_log2(cfg_log2_i, LO, HI);

  // One keep bit per index position: kept when below the effective size.
  for (genvar b = 0; b < IDX_W; b++) begin : g_mask
    localparam logic [CFG_W-1:0] BPOS = CFG_W'(b);
    assign mask_o[b] = (BPOS < eff_log2_o);
  end

endmodule

// File: rtl/fab_digit_tree.sv
module fab_digit_tree
  import fab_pkg::*;
#(
  parameter int NDIG = 7
) (
  input  logic [2*NDIG-1:0] digits_i,
  output bank_t             sum_o
);

  localparam int LEAVES = tree_leaves(NDIG);
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap-ordered tree: node 0 is the root, leaves start at LEAVES-1.
  bank_t node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NDIG) begin : g_used
      assign node[LEAVES-1+k] = digits_i[2*k +: 2];
    end else begin : g_pad
      assign node[LEAVES-1+k] = 2'b00;
    end
  end

  // Two-bit adders wrap naturally, giving the modulo-4 sum.
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];

endmodule

// File: rtl/fab_lane.sv
module fab_lane
  import fab_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] masked_o,
  output bank_t            bank_o,
  output logic [IDX_W-3:0] addr_o
);

  localparam int NDIG  = (IDX_W + 1) / 2;
  localparam int PAD_W = 2 * NDIG - IDX_W;

  logic [2*NDIG-1:0] digits;

  assign masked_o = idx_i & mask_i;

  if (PAD_W > 0) begin : g_pad
    assign digits = {{PAD_W{1'b0}}, masked_o};
  end else begin : g_nopad
    assign digits = masked_o;
  end

  fab_digit_tree #(.NDIG(NDIG)) tree_i (
    .digits_i (digits),
    .sum_o    (bank_o)
  );

  assign addr_o = masked_o[IDX_W-1:2];

endmodule

// File: rtl/four_bank_addr_gen.sv
module four_bank_addr_gen
  import fab_pkg::*;
#(
  parameter int IDX_W    = 13,
  parameter int MIN_LOG2 = 6,
  parameter int LANES    = 4
) (
  input  logic [CFG_W-1:0]             cfg_log2_i,
  input  logic [LANES*IDX_W-1:0]       idx_i,
  output logic [LANES*2-1:0]           bank_o,
  output logic [LANES*(IDX_W-2)-1:0]   addr_o
);

  localparam int ADDR_W = IDX_W - 2;

  // Named internal wires, observed by the bound checker.
  logic [CFG_W-1:0]       eff_log2;
  logic [IDX_W-1:0]       idx_mask;
  logic [LANES*IDX_W-1:0] lane_masked;

  fab_size_ctl #(.IDX_W(IDX_W), .MIN_LOG2(MIN_LOG2)) size_i (
    .cfg_log2_i (cfg_log2_i),
    .eff_log2_o (eff_log2),
    .mask_o     (idx_mask)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    fab_lane #(.IDX_W(IDX_W)) lane_i (
      .idx_i    (idx_i[n*IDX_W +: IDX_W]),
      .mask_i   (idx_mask),
      .masked_o (lane_masked[n*IDX_W +: IDX_W]),
      .bank_o   (bank_o[n*2 +: 2]),
      .addr_o   (addr_o[n*ADDR_W +: ADDR_W])
    );
  end

endmodule

// File: rtl/fab_addr_gen_chk.sv
module fab_addr_gen_chk
  import fab_pkg::*;
#(
  parameter int IDX_W    = 13,
  parameter int MIN_LOG2 = 6,
  parameter int LANES    = 4
) (
  input logic [CFG_W-1:0]           cfg_log2_i,
  input logic [LANES*2-1:0]         bank_o,
  input logic [LANES*(IDX_W-2)-1:0] addr_o,
  input logic [CFG_W-1:0]           eff_log2,
  input logic [LANES*IDX_W-1:0]     lane_masked
);

  localparam int ADDR_W = IDX_W - 2;
  localparam int NDIG   = (IDX_W + 1) / 2;

  function automatic bit single_digit(input logic [IDX_W-1:0] d);
    int cnt;
    cnt = 0;
    for (int k = 0; k < NDIG; k++)
      if (((d >> (2 * k)) & IDX_W'(3)) != '0) cnt++;
    return cnt == 1;
  endfunction

  always_comb begin
    assert_clamp_R4: assert (eff_log2 >= CFG_W'(MIN_LOG2) && eff_log2 <= CFG_W'(IDX_W) &&
                             ((cfg_log2_i < CFG_W'(MIN_LOG2) || cfg_log2_i > CFG_W'(IDX_W)) ||
                              eff_log2 == cfg_log2_i));
    for (int a = 0; a < LANES; a++) begin
      assert_mask_R3: assert ((lane_masked[a*IDX_W +: IDX_W] >> eff_log2) == '0);
      for (int b = a + 1; b < LANES; b++) begin
        // R7: equal inputs on two lanes give equal results.
        if (lane_masked[a*IDX_W +: IDX_W] == lane_masked[b*IDX_W +: IDX_W])
          assert_lane_match_R7: assert (bank_o[a*2 +: 2] == bank_o[b*2 +: 2] &&
                                        addr_o[a*ADDR_W +: ADDR_W] == addr_o[b*ADDR_W +: ADDR_W]);
        // R5: one-digit difference means different banks.
        if (single_digit(lane_masked[a*IDX_W +: IDX_W] ^ lane_masked[b*IDX_W +: IDX_W]))
          assert_digit_conflict_R5: assert (bank_o[a*2 +: 2] != bank_o[b*2 +: 2]);
        // R6: radix-2 partners across the top bit of an odd size.
        if (eff_log2[0] &&
            (lane_masked[a*IDX_W +: IDX_W] ^ lane_masked[b*IDX_W +: IDX_W]) ==
              (IDX_W'(1) << (eff_log2 - CFG_W'(1))))
          assert_radix2_conflict_R6: assert (bank_o[a*2 +: 2] != bank_o[b*2 +: 2]);
        // R8: a shared location implies the same index.
        if (bank_o[a*2 +: 2] == bank_o[b*2 +: 2] &&
            addr_o[a*ADDR_W +: ADDR_W] == addr_o[b*ADDR_W +: ADDR_W])
          assert_unique_loc_R8: assert (lane_masked[a*IDX_W +: IDX_W] ==
                                        lane_masked[b*IDX_W +: IDX_W]);
      end
    end
  end

endmodule

bind four_bank_addr_gen fab_addr_gen_chk #(
  .IDX_W(IDX_W), .MIN_LOG2(MIN_LOG2), .LANES(LANES)
) chk_i (
  .cfg_log2_i  (cfg_log2_i),
  .bank_o      (bank_o),
  .addr_o      (addr_o),
  .eff_log2    (eff_log2),
  .lane_masked (lane_masked)
);

// File: tb/four_bank_addr_gen_tb_top.sv
module four_bank_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 13;
  localparam int ADDR_W = IDX_W - 2;
  localparam int LANES  = 4;

  typedef struct {
    int bank;
    int addr;
    int grp;  // 0 plain, 1 radix-4 group, 2 radix-2 pairs, 3 occupancy sweep
    int tag;  // requirement number reported on a bank mismatch
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]               cfg = '0;
  logic [LANES*IDX_W-1:0]   idx = '0;
  logic [LANES*2-1:0]       bank;
  logic [LANES*ADDR_W-1:0]  addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb_q[$];
  int lv [LANES];
  bit seen [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  four_bank_addr_gen dut_i (
    .cfg_log2_i (cfg),
    .idx_i      (idx),
    .bank_o     (bank),
    .addr_o     (addr)
  );

  // Reference model: repeated division instead of bit slicing.
  function automatic int eff_of(input int c);
    if (c < 6) return 6;
    if (c > 13) return 13;
    return c;
  endfunction

  function automatic int ref_bank(input int ix, input int c);
    int v, s;
    v = ix % (1 << eff_of(c));
    s = 0;
    while (v > 0) begin
      s = s + v % 4;
      v = v / 4;
    end
    return s % 4;
  endfunction

  function automatic int ref_addr(input int ix, input int c);
    return (ix % (1 << eff_of(c))) / 4;
  endfunction

  task automatic note(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Driver: present lv[] on all lanes and push the expected results.
  task automatic apply(input int c, input int grp, input int tag);
    @(posedge clk);
    #1;
    cfg = 4'(c);
    for (int n = 0; n < LANES; n++) begin
      item_t it;
      idx[n*IDX_W +: IDX_W] = IDX_W'(lv[n]);
      it.bank = ref_bank(lv[n], c);
      it.addr = ref_addr(lv[n], c);
      it.grp  = grp;
      it.tag  = tag;
      sb_q.push_back(it);
    end
  endtask

  // Monitor: compare away from the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() >= LANES) begin
        int gb [LANES];
        int grp;
        grp = 0;
        for (int n = 0; n < LANES; n++) begin
          item_t it;
          int ab, aa;
          it = sb_q.pop_front();
          ab = int'(bank[n*2 +: 2]);
          aa = int'(addr[n*ADDR_W +: ADDR_W]);
          gb[n] = ab;
          grp = it.grp;
          note(ab == it.bank, $sformatf("R%0d lane %0d bank got %0d exp %0d", it.tag, n, ab, it.bank));
          note(aa == it.addr, $sformatf("R2 lane %0d addr got %0d exp %0d", n, aa, it.addr));
          if (grp == 3) begin
            // R8: each bank/address pair of the 64-point space used once.
            if (seen[ab*16 + (aa % 16)]) begin
              checks++; fails++;
              $display("FAIL R8 location bank %0d addr %0d reused got dup exp unique", ab, aa);
            end
            seen[ab*16 + (aa % 16)] = 1'b1;
          end
        end
        if (grp == 1) begin
          int mask;
          mask = 0;
          for (int n = 0; n < LANES; n++) mask = mask | (1 << gb[n]);
          note(mask == 15, $sformatf("R5 group bank set got %0h exp f", mask));
        end
        if (grp == 2) begin
          note(gb[0] != gb[1], $sformatf("R6 pair banks got %0d,%0d exp different", gb[0], gb[1]));
          note(gb[2] != gb[3], $sformatf("R6 pair banks got %0d,%0d exp different", gb[2], gb[3]));
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base, hold;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: all-zero inputs give bank 0, address 0 (R1, R2).
    note(bank == '0, $sformatf("R1 idle bank got %0h exp 0", bank));
    note(addr == '0, $sformatf("R2 idle addr got %0h exp 0", addr));

    // R5: full radix-4 groups at every digit position and size.
    for (int c = 6; c <= 13; c++) begin
      for (int p = 0; p < c / 2; p++) begin
        for (int r = 0; r < 3; r++) begin
          base = int'($urandom % (1 << c)) & ~(3 << (2 * p));
          for (int n = 0; n < LANES; n++) lv[n] = base | (((n + r) % 4) << (2 * p));
          apply(c, 1, 1);
        end
      end
    end

    // R6: radix-2 partners for odd sizes.
    for (int c = 7; c <= 13; c += 2) begin
      for (int r = 0; r < 4; r++) begin
        base = int'($urandom % (1 << (c - 1)));
        lv[0] = base; lv[1] = base | (1 << (c - 1));
        base = int'($urandom % (1 << (c - 1)));
        lv[2] = base | (1 << (c - 1)); lv[3] = base;
        apply(c, 2, 6);
      end
    end

    // R3: junk above the size boundary is ignored.
    for (int c = 6; c <= 12; c++) begin
      for (int n = 0; n < LANES; n++) lv[n] = int'($urandom % (1 << IDX_W)) | (1 << c);
      apply(c, 0, 3);
    end

    // R4: out-of-window size settings clamp.
    for (int k = 0; k < 4; k++) begin
      int cs [4] = '{0, 5, 14, 15};
      for (int n = 0; n < LANES; n++) lv[n] = int'($urandom % (1 << IDX_W));
      apply(cs[k], 0, 4);
    end

    // R7: lanes 1..3 held while lane 0 moves.
    lv[1] = 13'h0abc; lv[2] = 13'h1fff; lv[3] = 13'h0001;
    for (int v = 0; v < 6; v++) begin
      lv[0] = v * 1237 % (1 << IDX_W);
      apply(13, 0, 7);
    end

    // R8: exhaustive 64-point sweep.
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    for (int v = 0; v < 16; v++) begin
      for (int n = 0; n < LANES; n++) lv[n] = v * 4 + n;
      apply(6, 3, 8);
    end
    repeat (3) @(negedge clk);
    hold = 0;
    for (int i = 0; i < 64; i++) if (seen[i]) hold++;
    note(hold == 64, $sformatf("R8 occupied locations got %0d exp 64", hold));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule